// File: doc/BRIEF.md
# Receive Character Buffer with Flush on Overflow

This block sits between a UART character receiver and the host-side serial interface. Each received character arrives with its parity (ninth) bit and its framing-error flag, and all three are kept together in one entry. The host sees the oldest held character on the output pins together with a data-available flag. A read strobe removes that character at the next clock edge, so the next one is visible by then.

The buffer holds eight entries. If a character arrives while all eight are in use and no read happens in the same cycle, the block does not drop only the newest character. It throws away everything, including the new arrival. A shutdown request also empties the buffer, and so does any write to the configuration bit. When that bit is set, buffering is off. The block then behaves as a single holding register in which each new character replaces the previous one. The configuration bit is returned on a read-back output.

Top module: `rx_char_buffer`

## Requirements
- R1: Up to 8 characters are held and are presented strictly in arrival order: the output pins show the oldest held entry.
- R2: After reset the buffer is empty (`rx_avail` = 0) and buffering is enabled (`cfg_nobuf_q` = 0). `rx_avail` is 1 exactly when at least one character is held.
- R3: If a character arrives (`in_valid` = 1) while 8 are held and `rd_strobe` = 0, every held character and the new one are discarded. `rx_avail` is 0 after that edge.
- R4: While `shutdown` = 1, the buffer is emptied at each edge, and arrivals and read strobes have no effect. `rx_avail` is 0 after the first such edge.
- R5: A clock with `cfg_we` = 1 loads `cfg_nobuf` into the configuration bit, and the bit is returned on `cfg_nobuf_q` from the next cycle. A value of 1 disables buffering. Every such write also empties the buffer, and arrivals and reads in that cycle are ignored. `shutdown` takes priority over `cfg_we` for the buffer contents.
- R6: With `cfg_nobuf_q` = 1, at most one character is held. A new arrival replaces it. An arrival together with a read leaves the new character held.
- R7: A read strobe while `rx_avail` = 1 removes the oldest entry at that clock edge. A read strobe while the buffer is empty has no effect.
- R8: An arrival and a read in the same cycle while 8 are held act as a read followed by a write. No overflow occurs, 8 characters stay held, and the order continues.
- R9: The ninth bit and the framing-error flag of each character come out together with that character's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received character is offered this cycle |
| in_data | input | 8 | Received data bits |
| in_ninth | input | 1 | Received parity / ninth bit |
| in_ferr | input | 1 | Framing error seen on this character |
| rd_strobe | input | 1 | Host takes the oldest character |
| shutdown | input | 1 | Shutdown request; empties the buffer |
| cfg_we | input | 1 | Write to the configuration bit |
| cfg_nobuf | input | 1 | Value written: 1 disables buffering |
| cfg_nobuf_q | output | 1 | Read-back of the configuration bit |
| rx_avail | output | 1 | At least one character is held |
| rx_data | output | 8 | Oldest character's data (valid when rx_avail) |
| rx_ninth | output | 1 | Oldest character's ninth bit |
| rx_ferr | output | 1 | Oldest character's framing-error flag |

## Verification
The main path is driven by a vector table that mixes plain pushes, lone reads, reads on an empty buffer and pushes coinciding with reads, and it uses a different ninth-bit and error pattern on each character. This separates a correct ordering from swapped pointers, a lost simultaneous push from a lost pop, and status bits that have come apart from their data. Directed runs then fill the buffer completely. They compare a ninth arrival with no read, which must empty everything, against a ninth arrival with a read, which must keep eight in order. Further runs show that the single-register mode keeps only the latest character, and that shutdown and configuration writes both flush the buffer.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int unsigned RX_DATA_W = 8;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 ninth;
    logic                 ferr;
  } rx_entry_t;

  // Next slot index for a ring of 'depth' slots.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of buffered operation.
  function automatic int unsigned level_step(int unsigned lvl, logic push, logic pop);
    int unsigned r;
    r = lvl;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/rxbuf_cfg.sv
module rxbuf_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_nobuf,
  output logic nobuf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nobuf_q <= 1'b0;
    else if (cfg_we) nobuf_q <= cfg_nobuf;
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  rx_entry_t        wr_entry,
  input  logic [PTR_W-1:0] rd_addr,
  output rx_entry_t        rd_entry
);
  rx_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (wr_en && (wr_addr == PTR_W'(i)))
        slot_q[i] <= wr_entry;
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == PTR_W'(i)) rd_entry = slot_q[i];
  end
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             shutdown,
  input  logic             cfg_we,
  input  logic             nobuf,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             ovf_ev,
  output logic             push_ev,
  output logic             pop_ev,
  output logic             flush_ev
);
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             held, quiet;

  assign held  = (lvl_q != '0);
  assign full  = (lvl_q == CNT_W'(DEPTH));
  assign quiet = !shutdown && !cfg_we;

  // Event decode: a read is taken first, so a full buffer with a read
  // in the same cycle has room for the arrival.
  assign pop_ev   = quiet && pop_req && held;
  assign ovf_ev   = quiet && push_req && !nobuf && full && !pop_ev;
  assign push_ev  = quiet && push_req && !ovf_ev;
  assign flush_ev = shutdown || cfg_we || ovf_ev;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    lvl_d = lvl_q;
    if (flush_ev) begin
      rd_d  = '0;
      wr_d  = '0;
      lvl_d = '0;
    end else if (nobuf) begin
      rd_d = '0;
      wr_d = '0;
      if (push_ev)     lvl_d = CNT_W'(1);
      else if (pop_ev) lvl_d = '0;
    end else begin
      if (pop_ev)  rd_d = PTR_W'(ring_next(32'(rd_q), DEPTH));
      if (push_ev) wr_d = PTR_W'(ring_next(32'(wr_q), DEPTH));
      lvl_d = CNT_W'(level_step(32'(lvl_q), push_ev, pop_ev));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  assign wr_en   = push_ev;
  assign wr_addr = nobuf ? '0 : wr_q;
  assign rd_addr = rd_q;
  assign level   = lvl_q;
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [RX_DATA_W-1:0] in_data,
  input  logic                 in_ninth,
  input  logic                 in_ferr,
  input  logic                 rd_strobe,
  input  logic                 shutdown,
  input  logic                 cfg_we,
  input  logic                 cfg_nobuf,
  output logic                 cfg_nobuf_q,
  output logic                 rx_avail,
  output logic [RX_DATA_W-1:0] rx_data,
  output logic                 rx_ninth,
  output logic                 rx_ferr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic             wr_en, full, ovf_ev, push_ev, pop_ev, flush_ev;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0] level;
  rx_entry_t        in_entry, head;

  assign in_entry = '{data: in_data, ninth: in_ninth, ferr: in_ferr};

  rxbuf_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_nobuf (cfg_nobuf),
    .nobuf_q   (cfg_nobuf_q)
  );

  rxbuf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (in_valid),
    .pop_req  (rd_strobe),
    .shutdown (shutdown),
    .cfg_we   (cfg_we),
    .nobuf    (cfg_nobuf_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .level    (level),
    .full     (full),
    .ovf_ev   (ovf_ev),
    .push_ev  (push_ev),
    .pop_ev   (pop_ev),
    .flush_ev (flush_ev)
  );

  rxbuf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry (in_entry),
    .rd_addr  (rd_addr),
    .rd_entry (head)
  );

  assign rx_avail = (level != '0);
  assign rx_data  = head.data;
  assign rx_ninth = head.ninth;
  assign rx_ferr  = head.ferr;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             rd_strobe,
  input logic             shutdown,
  input logic             cfg_we,
  input logic             cfg_nobuf,
  input logic             cfg_nobuf_q,
  input logic             rx_avail,
  input logic [CNT_W-1:0] level,
  input logic             full,
  input logic             ovf_ev,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             flush_ev
);
  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  p_flush_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> !rx_avail);

  p_shutdown_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !rx_avail);

  p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_nobuf_q == $past(cfg_nobuf)) && !rx_avail);

  p_single_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_nobuf_q |-> level <= CNT_W'(1));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_avail && rd_strobe && !in_valid) |=> !rx_avail);

  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !push_ev && !flush_ev) |=> level == $past(level) - CNT_W'(1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && rd_strobe && !shutdown && !cfg_we) |-> !ovf_ev);

  p_stay_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && rd_strobe && !shutdown && !cfg_we) |=> level == CNT_W'(DEPTH));
endmodule

bind rx_char_buffer rxbuf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rd_strobe   (rd_strobe),
  .shutdown    (shutdown),
  .cfg_we      (cfg_we),
  .cfg_nobuf   (cfg_nobuf),
  .cfg_nobuf_q (cfg_nobuf_q),
  .rx_avail    (rx_avail),
  .level       (level),
  .full        (full),
  .ovf_ev      (ovf_ev),
  .push_ev     (push_ev),
  .pop_ev      (pop_ev),
  .flush_ev    (flush_ev)
);

// File: tb/sim_rx_char_buffer.sv
`timescale 1ns/1ps
module sim_rx_char_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ninth = 1'b0, in_ferr = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       rd_strobe = 1'b0, shutdown = 1'b0, cfg_we = 1'b0, cfg_nobuf = 1'b0;
  logic       cfg_nobuf_q, rx_avail, rx_ninth, rx_ferr;
  logic [7:0] rx_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_char_buffer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ninth(in_ninth), .in_ferr(in_ferr), .rd_strobe(rd_strobe),
    .shutdown(shutdown), .cfg_we(cfg_we), .cfg_nobuf(cfg_nobuf),
    .cfg_nobuf_q(cfg_nobuf_q), .rx_avail(rx_avail), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .rx_ferr(rx_ferr)
  );

  // Vector: {push, read, data[8], ninth, ferr, exp_avail, exp_data[8], exp_ninth, exp_ferr}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h22, 1'b0, 1'b1, 1'b1, 8'h11, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h44, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h44, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h66, 1'b0, 1'b1, 1'b1, 8'h66, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; inputs held over one rising edge; returns at next negedge.
  task automatic cyc(input logic push, input logic [7:0] d, input logic n,
                     input logic f, input logic rd);
    in_valid = push; in_data = d; in_ninth = n; in_ferr = f; rd_strobe = rd;
    @(negedge clk);
    in_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic cfg_write(input logic v);
    cfg_we = 1'b1; cfg_nobuf = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic head_is(input string req, input logic [7:0] d, input logic n, input logic f);
    chk(req, {31'd0, rx_avail}, 32'd1);
    chk(req, {24'd0, rx_data}, {24'd0, d});
    chk(req, {30'd0, rx_ninth, rx_ferr}, {30'd0, n, f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset avail", {31'd0, rx_avail}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset avail", {31'd0, rx_avail}, 32'd0);
    chk("R2 reset cfg", {31'd0, cfg_nobuf_q}, 32'd0);

    // Vector table: order, read timing, status travel (R1 R7 R9)
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      cyc(v[22], v[20:13], v[12], v[11], v[21]);
      chk($sformatf("R7 vec %0d avail", i), {31'd0, rx_avail}, {31'd0, v[10]});
      if (v[10]) begin
        chk($sformatf("R1 vec %0d data", i), {24'd0, rx_data}, {24'd0, v[9:2]});
        chk($sformatf("R9 vec %0d status", i), {30'd0, rx_ninth, rx_ferr}, {30'd0, v[1:0]});
      end
    end

    // Fill eight, drain in order (R1 R9)
    for (int i = 0; i < 8; i++) cyc(1'b1, 8'h10 + 8'(i), i[0], i[1], 1'b0);
    for (int i = 0; i < 8; i++) begin
      head_is("R1 R9 drain", 8'h10 + 8'(i), i[0], i[1]);
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    end
    chk("R2 drained empty", {31'd0, rx_avail}, 32'd0);

    // Overflow flushes everything including the arrival (R3)
    for (int i = 0; i < 8; i++) cyc(1'b1, 8'h20 + 8'(i), 1'b0, 1'b0, 1'b0);
    head_is("R3 full head", 8'h20, 1'b0, 1'b0);
    cyc(1'b1, 8'h99, 1'b1, 1'b1, 1'b0);
    chk("R3 overflow flush", {31'd0, rx_avail}, 32'd0);
    cyc(1'b1, 8'h5A, 1'b1, 1'b0, 1'b0);
    head_is("R3 after flush", 8'h5A, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

    // Push and read together while full (R8)
    for (int i = 0; i < 8; i++) cyc(1'b1, 8'h80 + 8'(i), 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'h88, 1'b1, 1'b1, 1'b1);
    for (int k = 1; k <= 8; k++) begin
      head_is("R8 order kept", 8'h80 + 8'(k), k == 8, k == 8);
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    end
    chk("R8 empty after nine", {31'd0, rx_avail}, 32'd0);

    // Shutdown flush and ignore (R4)
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h30 + 8'(i), 1'b0, 1'b0, 1'b0);
    shutdown = 1'b1;
    cyc(1'b1, 8'h3F, 1'b0, 1'b0, 1'b0);
    chk("R4 shutdown flush", {31'd0, rx_avail}, 32'd0);
    cyc(1'b1, 8'h3E, 1'b0, 1'b0, 1'b0);
    chk("R4 arrival ignored", {31'd0, rx_avail}, 32'd0);
    shutdown = 1'b0;
    @(negedge clk);
    chk("R4 still empty", {31'd0, rx_avail}, 32'd0);

    // Configuration write: read-back and flush (R5)
    cyc(1'b1, 8'h41, 1'b0, 1'b0, 1'b0);
    cfg_write(1'b1);
    chk("R5 readback one", {31'd0, cfg_nobuf_q}, 32'd1);
    chk("R5 write flushes", {31'd0, rx_avail}, 32'd0);

    // Single holding register (R6)
    cyc(1'b1, 8'hA1, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 8'hA2, 1'b1, 1'b0, 1'b0);
    head_is("R6 latest kept", 8'hA2, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R6 one held only", {31'd0, rx_avail}, 32'd0);
    cyc(1'b1, 8'hA3, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'hA4, 1'b1, 1'b1, 1'b1);
    head_is("R6 push with read", 8'hA4, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b1, 8'hB0 + 8'(i), 1'b0, 1'b0, 1'b0);
    head_is("R6 no overflow flush", 8'hB9, 1'b0, 1'b0);

    // Back to buffered mode (R5)
    cfg_write(1'b0);
    chk("R5 readback zero", {31'd0, cfg_nobuf_q}, 32'd0);
    chk("R5 flush on clear", {31'd0, rx_avail}, 32'd0);
    cyc(1'b1, 8'hC1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'hC2, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    head_is("R5 buffered again", 8'hC2, 1'b1, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule